// File: doc/BRIEF.md
# Programmable Interrupt Source Selector

This block sits between a pool of sixteen peripheral event lines and the twelve maskable interrupt inputs of a processor core, numbered INT4 through INT15. Rather than wiring each peripheral to a fixed interrupt, software writes a 4-bit source code for every interrupt input. The codes are packed six to a word into two 32-bit registers. Each clock, every interrupt output is loaded from the event line its code names, so the core sees a registered copy of the chosen event one cycle later.

The source codes index the event bus directly. Code 0 is the host-port event. Codes 1 and 2 are the two timers, and code 3 is the memory refresh event. Codes 4 to 7 are external pins 4 to 7, codes 8 to 11 are the four DMA channels, and codes 12 to 15 are the transmit and receive events of two serial ports. A small register port gives word reads and writes. A two-state access machine returns read data one cycle after the request. It has two states: `ACC_IDLE` and `ACC_RESP`. A read request in either state moves it to `ACC_RESP`, and a cycle without a read request returns it to `ACC_IDLE`.

Top module: `irq_route_mux`

## Requirements
- R1: After reset, the interrupt outputs are 0, `rd_valid` is 0, and the field for interrupt INT(4+k) holds code (k+4) mod 16. This makes INT4..INT15 default to codes 4..15.
- R2: The register at byte offset 0 carries the fields of INT10..INT15, and offset 4 carries INT4..INT9. In each register the six 4-bit fields start at bits 0, 5, 10, 16, 21 and 26, with the lowest-numbered interrupt in the lowest field. For example, code 5 at bits 13:10 of offset 0 routes external pin 5 to INT12.
- R3: Output bit k (INT(4+k)) equals `src_evt[code]` for that line's code, as sampled at the previous clock edge. A one-cycle event pulse therefore gives a one-cycle output pulse, one cycle later.
- R4: When several interrupt fields hold the same code, all of those outputs follow that one event line.
- R5: Bits 4, 9, 14, 15, 20, 25, 30 and 31 of both registers always read 0, and write data on those bits is discarded.
- R6: A write to any address other than 0 and 4 changes no field, and a read from such an address returns 0.
- R7: A read request raises `rd_valid` with the data on the next cycle, and back-to-back requests give back-to-back responses. In a cycle after no read request, `rd_valid` is 0.
- R8: A write updates the fields at its clock edge. Routing through the new code is therefore seen one cycle later than routing through the old code: the output cycle right after the write still reflects the old code.
- R9: A write to one register leaves every field of the other register unchanged. With no write request, no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write strobe for one full word |
| rd_req | input | 1 | Read strobe |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_valid is 1 |
| rd_valid | output | 1 | Read response flag |
| src_evt | input | 16 | Peripheral event lines indexed by source code |
| cpu_irq | output | 12 | Routed interrupts; bit k drives INT(4+k) |

## Verification
The hardest case to reach from the ports is the cycle where a new select code has just been stored but the output register still holds a value routed through the old one. The bench writes a new code for INT15 in the same cycle that it drives an event which only the new code selects. It then samples the output on both following cycles, expecting the old routing first and the new routing second. Shared-source fan-out is reached by an all-ones write, which sets every INT4..INT9 field to the same code as the INT15 default. That same write also exercises the discarding of gap bits.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned IR_REG_W          = 32;
    localparam int unsigned IR_SEL_W          = 4;
    localparam int unsigned IR_NUM_SRC        = 16;
    localparam int unsigned IR_NUM_LINES      = 12;
    localparam int unsigned IR_FIELDS_PER_REG = 6;
    localparam int unsigned IR_FIRST_LINE     = 4;
    localparam int unsigned IR_ADDR_W         = 3;
    localparam int unsigned IR_NUM_REGS       =
        (IR_NUM_LINES + IR_FIELDS_PER_REG - 1) / IR_FIELDS_PER_REG;

    // read-side access machine
    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    // lowest bit of field slot s: one spare bit after every field,
    // plus an extra spare bit at the half-word boundary
    function automatic int unsigned field_lsb(input int unsigned slot);
        return slot * (IR_SEL_W + 1) + ((slot >= 3) ? 1 : 0);
    endfunction

    // higher-numbered lines live in the lower register offset
    function automatic int unsigned reg_of_line(input int unsigned line);
        return IR_NUM_REGS - 1 - (line / IR_FIELDS_PER_REG);
    endfunction

    function automatic int unsigned default_code(input int unsigned line);
        return (line + IR_FIRST_LINE) % IR_NUM_SRC;
    endfunction

    // bits of a register that hold select fields
    function automatic logic [IR_REG_W-1:0] field_mask();
        logic [IR_REG_W-1:0] m;
        m = '0;
        for (int unsigned s = 0; s < IR_FIELDS_PER_REG; s++) begin
            m[field_lsb(s) +: IR_SEL_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W   = IR_ADDR_W,
    parameter int unsigned NUM_REGS = IR_NUM_REGS
) (
    input  logic [ADDR_W-1:0]                     addr,
    output logic                                  hit,
    output logic [$clog2(NUM_REGS > 1 ? NUM_REGS : 2)-1:0] reg_idx
);
    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned RIDX_W   = $clog2(NUM_REGS > 1 ? NUM_REGS : 2);

    logic [ADDR_W-1:0] word_num;

    always_comb begin
        word_num = addr >> WORD_LSB;
        hit      = (addr[WORD_LSB-1:0] == '0) && (word_num < ADDR_W'(NUM_REGS));
        reg_idx  = word_num[RIDX_W-1:0];
    end

endmodule

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned REG_W          = IR_REG_W,
    parameter int unsigned SEL_W          = IR_SEL_W,
    parameter int unsigned NUM_LINES      = IR_NUM_LINES,
    parameter int unsigned NUM_REGS       = IR_NUM_REGS,
    parameter int unsigned RIDX_W         = $clog2(NUM_REGS > 1 ? NUM_REGS : 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [RIDX_W-1:0]           wr_reg,
    input  logic [REG_W-1:0]            wdata,
    input  logic [RIDX_W-1:0]           rd_reg,
    output logic [REG_W-1:0]            rd_word,
    output logic [NUM_LINES*SEL_W-1:0]  sel_flat
);
    logic [SEL_W-1:0] sel_q   [NUM_LINES];
    logic [REG_W-1:0] contrib [NUM_LINES];

    // spare bits of the write word are dropped on purpose
    logic unused_gap_bits;
    assign unused_gap_bits = ^(wdata & ~field_mask());

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        localparam int unsigned REG_IDX = reg_of_line(k);
        localparam int unsigned LSB     = field_lsb(k % IR_FIELDS_PER_REG);
        localparam logic [SEL_W-1:0] RST_CODE = SEL_W'(default_code(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[k] <= RST_CODE;
            end else if (wr_en && (wr_reg == RIDX_W'(REG_IDX))) begin
                sel_q[k] <= wdata[LSB +: SEL_W];
            end
        end

        assign contrib[k] = (rd_reg == RIDX_W'(REG_IDX))
                          ? (REG_W'(sel_q[k]) << LSB) : '0;
        assign sel_flat[k*SEL_W +: SEL_W] = sel_q[k];
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            rd_word = rd_word | contrib[k];
        end
    end

endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
    import irq_route_pkg::*;
#(
    parameter int unsigned SEL_W     = IR_SEL_W,
    parameter int unsigned NUM_SRC   = IR_NUM_SRC,
    parameter int unsigned NUM_LINES = IR_NUM_LINES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_evt,
    input  logic [NUM_LINES*SEL_W-1:0] sel_flat,
    output logic [NUM_LINES-1:0]       irq_out
);
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_route
        logic [SEL_W-1:0] code;
        assign code = sel_flat[k*SEL_W +: SEL_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_out[k] <= 1'b0;
            end else begin
                irq_out[k] <= src_evt[code];
            end
        end
    end

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W    = IR_ADDR_W,
    parameter int unsigned REG_W     = IR_REG_W,
    parameter int unsigned SEL_W     = IR_SEL_W,
    parameter int unsigned NUM_SRC   = IR_NUM_SRC,
    parameter int unsigned NUM_LINES = IR_NUM_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_req,
    input  logic                 rd_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic                 rd_valid,
    input  logic [NUM_SRC-1:0]   src_evt,
    output logic [NUM_LINES-1:0] cpu_irq
);
    localparam int unsigned NUM_REGS = (NUM_LINES + IR_FIELDS_PER_REG - 1) / IR_FIELDS_PER_REG;
    localparam int unsigned RIDX_W   = $clog2(NUM_REGS > 1 ? NUM_REGS : 2);

    logic                       addr_hit;
    logic [RIDX_W-1:0]          addr_reg;
    logic [REG_W-1:0]           rd_word;
    logic [NUM_LINES*SEL_W-1:0] sel_flat;
    logic [REG_W-1:0]           rdata_q;
    acc_state_e                 state_q, state_d;

    irq_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .addr    (addr),
        .hit     (addr_hit),
        .reg_idx (addr_reg)
    );

    irq_sel_regs #(
        .REG_W     (REG_W),
        .SEL_W     (SEL_W),
        .NUM_LINES (NUM_LINES),
        .NUM_REGS  (NUM_REGS),
        .RIDX_W    (RIDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && addr_hit),
        .wr_reg   (addr_reg),
        .wdata    (wdata),
        .rd_reg   (addr_reg),
        .rd_word  (rd_word),
        .sel_flat (sel_flat)
    );

    irq_line_mux #(
        .SEL_W     (SEL_W),
        .NUM_SRC   (NUM_SRC),
        .NUM_LINES (NUM_LINES)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .sel_flat (sel_flat),
        .irq_out  (cpu_irq)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_req)  state_d = ACC_RESP;
            ACC_RESP: if (!rd_req) state_d = ACC_IDLE;
            default:               state_d = ACC_IDLE;
        endcase
    end

    // read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= addr_hit ? rd_word : '0;
        end
    end

    // outputs
    always_comb begin
        rd_valid = 1'b0;
        rdata    = '0;
        unique case (state_q)
            ACC_IDLE: rd_valid = 1'b0;
            ACC_RESP: begin
                rd_valid = 1'b1;
                rdata    = rdata_q;
            end
            default:  rd_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned REG_W     = IR_REG_W,
    parameter int unsigned SEL_W     = IR_SEL_W,
    parameter int unsigned NUM_SRC   = IR_NUM_SRC,
    parameter int unsigned NUM_LINES = IR_NUM_LINES
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_req,
    input logic                       rd_req,
    input logic [REG_W-1:0]           rdata,
    input logic                       rd_valid,
    input logic [NUM_SRC-1:0]         src_evt,
    input logic [NUM_LINES-1:0]       cpu_irq,
    input logic [NUM_LINES*SEL_W-1:0] sel_flat
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
        // R3 and R4: each output is last cycle's event picked by its code
        a_r3_routed_line: assert property (@(posedge clk) disable iff (!rst_n)
            seen |-> (cpu_irq[k] == $past(src_evt[sel_flat[k*SEL_W +: SEL_W]])));
    end

    // R5: spare bits never read as one
    a_r5_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rdata & ~field_mask()) == '0));

    // R7: one response per request, none otherwise
    a_r7_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R9: codes only move on a write
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(sel_flat));

endmodule

bind irq_route_mux irq_route_chk #(
    .REG_W     (REG_W),
    .SEL_W     (SEL_W),
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .rdata    (rdata),
    .rd_valid (rd_valid),
    .src_evt  (src_evt),
    .cpu_irq  (cpu_irq),
    .sel_flat (sel_flat)
);

// File: tb/sim_irq_route_mux.sv
module sim_irq_route_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic        rd_req = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic [15:0] src_evt = '0;
    logic [11:0] cpu_irq;

    always #4 clk = ~clk;

    irq_route_mux u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rd_valid (rd_valid),
        .src_evt  (src_evt),
        .cpu_irq  (cpu_irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int model_sel [12];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    localparam int LSB_TAB [6] = '{0, 5, 10, 16, 21, 26};

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // R2 layout: lines 6..11 at offset 0, lines 0..5 at offset 4
    function automatic logic [31:0] pack_word(input int r);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 12; k++) begin
            if (((k >= 6) ? 0 : 1) == r) w = w | (32'(model_sel[k]) << LSB_TAB[k % 6]);
        end
        return w;
    endfunction

    function automatic logic [11:0] route(input logic [15:0] p);
        logic [11:0] r;
        for (int k = 0; k < 12; k++) r[k] = p[model_sel[k]];
        return r;
    endfunction

    function automatic logic [31:0] expect_read(input logic [2:0] a);
        if (a == 3'd0) return pack_word(0);
        if (a == 3'd4) return pack_word(1);
        return 32'h0;
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [31:0] d);
        for (int k = 0; k < 12; k++) begin
            if ((a == 3'd0 && k >= 6) || (a == 3'd4 && k < 6))
                model_sel[k] = int'(d[LSB_TAB[k % 6] +: 4]);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_req = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_req = 1'b0;
        model_write(a, d);
    endtask

    // driver: pushes the expected word, monitor pops it
    task automatic bus_read(input logic [2:0] a, input string tag);
        @(negedge clk);
        rd_req = 1'b1; addr = a;
        exp_q.push_back(expect_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic route_step(input logic [15:0] p, input string tag);
        @(negedge clk);
        src_evt = p;
        @(negedge clk);
        check32(tag, 32'(cpu_irq), 32'(route(p)));
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R7 unrequested response: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check32(t, rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [15:0] pat;
        logic [11:0] old_exp;
        for (int k = 0; k < 12; k++) model_sel[k] = (k + 4) % 16;

        repeat (3) @(negedge clk);
        check32("R1 irq in reset", 32'(cpu_irq), 32'h0);
        check32("R1 rd_valid in reset", 32'(rd_valid), 32'h0);
        rst_n = 1'b1;

        bus_read(3'd0, "R1 default offset 0");
        bus_read(3'd4, "R1 default offset 4");

        route_step(16'h0010, "R3 pin4 to INT4");
        route_step(16'h8001, "R3 two sources");
        route_step(16'hA5A5, "R3 mixed pattern");
        route_step(16'h0100, "R3 pulse high");
        route_step(16'h0000, "R3 pulse ends");

        // code 5 into INT12 (bits 13:10 of offset 0)
        w = (expect_read(3'd0) & ~(32'hF << 10)) | (32'd5 << 10);
        bus_write(3'd0, w);
        bus_read(3'd0, "R2 INT12 field readback");
        route_step(16'h0020, "R4 pin5 on INT5 and INT12");
        check32("R2 INT12 follows pin5", 32'(cpu_irq), 32'h102);

        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_read(3'd4, "R5 gap bits after all-ones");
        route_step(16'h8000, "R4 code15 on seven lines");
        check32("R4 shared fan-out", 32'(cpu_irq), 32'h83F);
        bus_read(3'd0, "R9 offset 0 kept");

        bus_write(3'd2, 32'h0000_0000);
        bus_write(3'd6, 32'h0000_0000);
        bus_read(3'd2, "R6 unmapped read");
        bus_read(3'd4, "R6 offset 4 unchanged");
        bus_read(3'd0, "R6 offset 0 unchanged");

        // R8: move INT15 to code 3 while driving source 3
        @(negedge clk);
        src_evt = 16'h0008;
        w = (expect_read(3'd0) & ~(32'hF << 26)) | (32'd3 << 26);
        wr_req = 1'b1; addr = 3'd0; wdata = w;
        pat = 16'h0008;
        old_exp = route(pat);
        @(negedge clk);
        wr_req = 1'b0;
        check32("R8 old code first", 32'(cpu_irq), 32'(old_exp));
        model_write(3'd0, w);
        @(negedge clk);
        check32("R8 new code next", 32'(cpu_irq), 32'(route(pat)));

        // R7 back-to-back reads then idle
        @(negedge clk);
        rd_req = 1'b1; addr = 3'd0;
        exp_q.push_back(expect_read(3'd0)); tag_q.push_back("R7 first of pair");
        @(negedge clk);
        addr = 3'd4;
        exp_q.push_back(expect_read(3'd4)); tag_q.push_back("R7 second of pair");
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        check32("R7 idle after reads", 32'(rd_valid), 32'h0);
        check32("R7 all responses seen", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule